// File: doc/BRIEF.md
# Serial Character Receiver with Line Status

This block converts an asynchronous serial line into parallel characters and keeps the receive-side line status flags that a CPU polls. It runs on a one-cycle enable that pulses sixteen times per bit period. The line passes through a two-flop synchronizer. A falling edge starts a character, and the block checks that the start bit is still low halfway through the bit. Each later bit is sampled once, at the middle of the bit.

The character format comes from static inputs: the word length, the stop bit select, parity enable, even select and stick parity. A loopback input swaps the receive source from the external pin to the local transmitter's serial output. Two single-cycle read strobes model the CPU bus. One read takes the character buffer and clears Data Ready. The other read takes the status and clears the four error flags.

Top module: `uart_rx_status`

## Requirements
- R1: After reset `rx_data_o` is 0, and `ready_o`, `overrun_o`, `par_err_o`, `frame_err_o` and `break_o` are all 0.
- R2: `wlen_i` selects the number of data bits as 5 + `wlen_i` (0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8). The first data bit on the line lands in bit 0 of `rx_data_o`, and data bits that are not received read as 0. A completed character sets `ready_o`.
- R3: A low pulse that has ended before the middle of the start bit does not start a character, so `ready_o` stays 0.
- R4: With `par_en_i`=1, a parity bit follows the last data bit. `even_i`=1 expects an even count of ones over data plus parity, and `even_i`=0 expects an odd count. A mismatch sets `par_err_o`.
- R5: With `par_en_i`=1 and `stick_i`=1, the expected parity bit is the complement of `even_i`, whatever the data. A mismatch sets `par_err_o`.
- R6: A stop bit sampled low sets `frame_err_o`.
- R7: With `stop2_i`=1 and a word length of 6 to 8 bits, a second stop bit is checked, and a low second stop bit sets `frame_err_o`.
- R8: When the data, parity and stop positions are all sampled low, `break_o` sets and `ready_o` sets, and `rx_data_o` reads 0.
- R9: When a character completes while `ready_o` is 1 and no buffer read comes in that cycle, `overrun_o` sets and `rx_data_o` takes the new character.
- R10: `overrun_o`, `par_err_o`, `frame_err_o` and `break_o` stay set through later error-free characters. A `lsr_rd_i` pulse clears all four and leaves `ready_o` unchanged.
- R11: A `rbr_rd_i` pulse clears `ready_o`.
- R12: With `loop_i`=1, characters come from `loop_txd_i` and activity on `rxd_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Enable pulsing 16 times per bit period |
| rxd_i | input | 1 | External serial input, idle high |
| loop_i | input | 1 | Loopback select |
| loop_txd_i | input | 1 | Local transmitter serial output, used as the source in loopback |
| wlen_i | input | 2 | Word length code, 5 + value data bits |
| stop2_i | input | 1 | Second stop bit check for 6 to 8 bit words |
| par_en_i | input | 1 | Parity enable |
| even_i | input | 1 | Even parity select |
| stick_i | input | 1 | Stick parity |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| lsr_rd_i | input | 1 | Status read strobe |
| rx_data_o | output | 8 | Received character, right-justified |
| ready_o | output | 1 | Data Ready |
| overrun_o | output | 1 | Overrun error |
| par_err_o | output | 1 | Parity error |
| frame_err_o | output | 1 | Framing error |
| break_o | output | 1 | Break detected |

## Verification
The bench sends a short low glitch. A design that skips the mid-start check would treat it as a start bit and frame a spurious character. It sends the same pattern at every word length. A design that shifts the word in from the wrong end would leave stale or misplaced upper bits. It sends good frames after bad ones and checks that the error flags are still set, because a design that rewrites the flags on each character would lose them. It also covers an all-zero frame, two unread characters in a row, and a loopback run with the external pin held low. These cases catch a missing break or overrun flag and a source mux that lets the external pin through.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       pe;
    logic       fe;
    logic       bi;
  } rx_char_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  input  logic loop_i,
  input  logic loop_txd_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              src;

  assign src = loop_i ? loop_txd_i : rxd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], src};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign line_o = sync_q[STAGES-1];
  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic       fall_i,
  input  logic [1:0] wlen_i,
  input  logic       stop2_i,
  input  logic       par_en_i,
  input  logic       even_i,
  input  logic       stick_i,
  output logic       done_o,
  output rx_char_t   char_o
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OVERSAMPLE - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              fall_seen_q, par_acc_q, par_bit_q, any_one_q, stop1_low_q;
  logic              two_stop, last_idx, exp_par, stop_fe;

  assign two_stop = stop2_i & (wlen_i != 2'd0);
  assign last_idx = (idx_q == IDX_W'(wlen_i) + IDX_W'(DATA_W - 4));
  // stick parity forces the complement of even select
  assign exp_par  = stick_i ? ~even_i : (even_i ? par_acc_q : ~par_acc_q);
  assign stop_fe  = ~line_i | ((state_q == ST_STOP2) & stop1_low_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      shreg_q     <= '0;
      fall_seen_q <= 1'b0;
      par_acc_q   <= 1'b0;
      par_bit_q   <= 1'b0;
      any_one_q   <= 1'b0;
      stop1_low_q <= 1'b0;
      done_o      <= 1'b0;
      char_o      <= '0;
    end else begin
      done_o <= 1'b0;
      if (state_q == ST_IDLE && fall_i) fall_seen_q <= 1'b1;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (fall_seen_q) begin
            state_q     <= ST_START;
            cnt_q       <= '0;
            fall_seen_q <= 1'b0;
          end
          ST_START: if (cnt_q == MID_C) begin
            cnt_q <= '0;
            if (!line_i) begin
              state_q   <= ST_DATA;
              idx_q     <= '0;
              shreg_q   <= '0;
              par_acc_q <= 1'b0;
              par_bit_q <= 1'b0;
              any_one_q <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
          default: if (cnt_q == LAST_C) begin
            cnt_q     <= '0;
            any_one_q <= any_one_q | line_i;
            unique case (state_q)
              ST_DATA: begin
                shreg_q[idx_q] <= line_i;
                par_acc_q      <= par_acc_q ^ line_i;
                if (last_idx) state_q <= par_en_i ? ST_PAR : ST_STOP1;
                else          idx_q   <= idx_q + 1'b1;
              end
              ST_PAR: begin
                par_bit_q <= line_i;
                state_q   <= ST_STOP1;
              end
              default: begin
                stop1_low_q <= ~line_i;
                if (state_q == ST_STOP1 && two_stop) begin
                  state_q <= ST_STOP2;
                end else begin
                  state_q     <= ST_IDLE;
                  done_o      <= 1'b1;
                  char_o.data <= shreg_q;
                  char_o.pe   <= par_en_i & (par_bit_q != exp_par);
                  char_o.fe   <= stop_fe;
                  char_o.bi   <= ~any_one_q & ~line_i;
                end
              end
            endcase
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        endcase
      end
    end
  end

  // R2
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && wlen_i == 2'd0) |-> (char_o.data[7:5] == 3'b000));
  // R8
  break_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && char_o.bi) |-> (char_o.fe && char_o.data == '0));
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  rx_char_t   char_i,
  input  logic       rbr_rd_i,
  input  logic       lsr_rd_i,
  output logic [7:0] rx_data_o,
  output logic       ready_o,
  output logic       overrun_o,
  output logic       par_err_o,
  output logic       frame_err_o,
  output logic       break_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o   <= '0;
      ready_o     <= 1'b0;
      overrun_o   <= 1'b0;
      par_err_o   <= 1'b0;
      frame_err_o <= 1'b0;
      break_o     <= 1'b0;
    end else begin
      if (lsr_rd_i) begin
        overrun_o   <= 1'b0;
        par_err_o   <= 1'b0;
        frame_err_o <= 1'b0;
        break_o     <= 1'b0;
      end
      if (rbr_rd_i) ready_o <= 1'b0;
      // a new character wins over a clear in the same cycle
      if (done_i) begin
        rx_data_o <= char_i.data;
        ready_o   <= 1'b1;
        if (ready_o && !rbr_rd_i) overrun_o <= 1'b1;
        if (char_i.pe) par_err_o   <= 1'b1;
        if (char_i.fe) frame_err_o <= 1'b1;
        if (char_i.bi) break_o     <= 1'b1;
      end
    end
  end

  // R8
  break_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && char_i.bi) |=> (ready_o && break_o));
  // R9
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && ready_o && !rbr_rd_i) |=> overrun_o);
  // R10
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((par_err_o || frame_err_o) && !lsr_rd_i) |=> (par_err_o || frame_err_o));
  // R10
  lsr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !done_i) |=> !(overrun_o || par_err_o || frame_err_o || break_o));
  // R11
  ready_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rbr_rd_i && !done_i) |=> !ready_o);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick16_i,
  input  logic       rxd_i,
  input  logic       loop_i,
  input  logic       loop_txd_i,
  input  logic [1:0] wlen_i,
  input  logic       stop2_i,
  input  logic       par_en_i,
  input  logic       even_i,
  input  logic       stick_i,
  input  logic       rbr_rd_i,
  input  logic       lsr_rd_i,
  output logic [7:0] rx_data_o,
  output logic       ready_o,
  output logic       overrun_o,
  output logic       par_err_o,
  output logic       frame_err_o,
  output logic       break_o
);
  logic     line, fall, done;
  rx_char_t rx_char;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .rxd_i, .loop_i, .loop_txd_i,
    .line_o(line), .fall_o(fall)
  );

  uart_rx_frame #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(8)) u_frame (
    .clk_i, .rst_ni, .tick_i(tick16_i), .line_i(line), .fall_i(fall),
    .wlen_i, .stop2_i, .par_en_i, .even_i, .stick_i,
    .done_o(done), .char_o(rx_char)
  );

  uart_rx_flags u_flags (
    .clk_i, .rst_ni, .done_i(done), .char_i(rx_char),
    .rbr_rd_i, .lsr_rd_i, .rx_data_o, .ready_o,
    .overrun_o, .par_err_o, .frame_err_o, .break_o
  );
endmodule

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CYC    = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rxd = 1'b1, loop_en = 1'b0, ltx = 1'b1;
  logic [1:0] wlen = 2'd3;
  logic stop2 = 0, par_en = 0, even = 0, stick = 0, rbr_rd = 0, lsr_rd = 0;
  logic [7:0] rx_data;
  logic ready, ovr, perr, ferr, brk;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_status u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(1'b1), .rxd_i(rxd),
    .loop_i(loop_en), .loop_txd_i(ltx), .wlen_i(wlen), .stop2_i(stop2),
    .par_en_i(par_en), .even_i(even), .stick_i(stick),
    .rbr_rd_i(rbr_rd), .lsr_rd_i(lsr_rd), .rx_data_o(rx_data),
    .ready_o(ready), .overrun_o(ovr), .par_err_o(perr),
    .frame_err_o(ferr), .break_o(brk)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_line(input logic v, input bit use_loop);
    if (use_loop) ltx = v; else rxd = v;
  endtask

  // start bit, data LSB first, optional parity, stops; then idle
  task automatic send(input logic [7:0] d, input int nb, input bit use_par,
                      input logic pbit, input logic s1, input logic s2,
                      input int nstop, input bit use_loop);
    logic [15:0] bits;
    int n = 0;
    bits = '0;
    bits[n++] = 1'b0;
    for (int i = 0; i < nb; i++) bits[n++] = d[i];
    if (use_par) bits[n++] = pbit;
    bits[n++] = s1;
    if (nstop == 2) bits[n++] = s2;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); set_line(bits[i], use_loop);
      repeat (BIT_CYC - 1) @(negedge clk);
    end
    @(negedge clk); set_line(1'b1, use_loop);
    repeat (24) @(negedge clk);
  endtask

  task automatic good(input logic [7:0] d);
    send(d, 8, 0, 0, 1, 1, 1, 0);
  endtask

  task automatic pulse_rd(input bit rbr, input bit lsr);
    @(negedge clk); rbr_rd = rbr; lsr_rd = lsr;
    @(negedge clk); rbr_rd = 0; lsr_rd = 0;
  endtask

  task automatic clear_all();
    pulse_rd(1, 1);
  endtask

  task automatic t_reset();
    chk("R1 data", rx_data, 0); chk("R1 ready", ready, 0);
    chk("R1 overrun", ovr, 0); chk("R1 parity", perr, 0);
    chk("R1 framing", ferr, 0); chk("R1 break", brk, 0);
  endtask

  task automatic t_wlen();
    for (int w = 0; w < 4; w++) begin
      wlen = 2'(w);
      send(8'hA5, 5 + w, 0, 0, 1, 1, 1, 0);
      chk("R2 data", rx_data, 8'hA5 & ((1 << (5 + w)) - 1));
      chk("R2 ready", ready, 1);
      chk("R2 no error", {perr, ferr, brk}, 0);
      pulse_rd(1, 0);
      chk("R11 ready cleared", ready, 0);
      clear_all();
    end
    wlen = 2'd3;
  endtask

  task automatic t_glitch();
    @(negedge clk); rxd = 0;
    repeat (4) @(negedge clk);
    rxd = 1;
    repeat (BIT_CYC * 12) @(negedge clk);
    chk("R3 glitch rejected", ready, 0);
  endtask

  task automatic t_parity();
    logic [7:0] d = 8'h37;
    par_en = 1;
    even = 1;
    send(d, 8, 1, ^d, 1, 1, 1, 0);
    chk("R4 even ok", perr, 0); chk("R4 even data", rx_data, d);
    clear_all();
    send(d, 8, 1, ~^d, 1, 1, 1, 0);
    chk("R4 even bad", perr, 1); clear_all();
    even = 0;
    send(d, 8, 1, ~^d, 1, 1, 1, 0);
    chk("R4 odd ok", perr, 0); clear_all();
    send(d, 8, 1, ^d, 1, 1, 1, 0);
    chk("R4 odd bad", perr, 1); clear_all();
  endtask

  task automatic t_stick();
    stick = 1; even = 0;
    send(8'h01, 8, 1, 1, 1, 1, 1, 0);
    chk("R5 stick ok", perr, 0); clear_all();
    send(8'h03, 8, 1, 0, 1, 1, 1, 0);
    chk("R5 stick bad", perr, 1); clear_all();
    even = 1;
    send(8'h01, 8, 1, 0, 1, 1, 1, 0);
    chk("R5 stick even ok", perr, 0); clear_all();
    stick = 0; par_en = 0; even = 0;
  endtask

  task automatic t_frame();
    send(8'h5C, 8, 0, 0, 0, 1, 1, 0);
    chk("R6 framing", ferr, 1); chk("R6 no break", brk, 0);
    clear_all();
    stop2 = 1;
    send(8'h3C, 8, 0, 0, 1, 1, 2, 0);
    chk("R7 two stops ok", ferr, 0); chk("R7 data", rx_data, 8'h3C);
    clear_all();
    send(8'h3C, 8, 0, 0, 1, 0, 2, 0);
    chk("R7 second stop low", ferr, 1); clear_all();
    stop2 = 0;
  endtask

  task automatic t_break();
    par_en = 1; even = 1;
    send(8'h00, 8, 1, 0, 0, 0, 1, 0);
    chk("R8 break", brk, 1); chk("R8 ready", ready, 1);
    chk("R8 data", rx_data, 0);
    clear_all();
    par_en = 0; even = 0;
  endtask

  task automatic t_overrun();
    good(8'h11);
    chk("R9 first no overrun", ovr, 0);
    good(8'h22);
    chk("R9 overrun", ovr, 1); chk("R9 newest kept", rx_data, 8'h22);
    clear_all();
  endtask

  task automatic t_sticky();
    send(8'h0F, 8, 0, 0, 0, 1, 1, 0);
    good(8'h44);
    chk("R10 framing sticky", ferr, 1);
    chk("R10 overrun sticky", ovr, 1);
    pulse_rd(0, 1);
    chk("R10 cleared", {ovr, perr, ferr, brk}, 0);
    chk("R10 ready kept", ready, 1);
    clear_all();
  endtask

  task automatic t_loop();
    loop_en = 1;
    @(negedge clk); rxd = 0;
    send(8'h5A, 8, 0, 0, 1, 1, 1, 1);
    chk("R12 loop data", rx_data, 8'h5A); chk("R12 loop ready", ready, 1);
    chk("R12 loop no error", {ferr, brk}, 0);
    clear_all();
    rxd = 1;
    good(8'h99);
    chk("R12 external ignored", ready, 0);
    loop_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_wlen();
    t_glitch();
    t_parity();
    t_stick();
    t_frame();
    t_break();
    t_overrun();
    t_sticky();
    t_loop();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule